// File: doc/BRIEF.md
# Dithered Counter-Comparator PWM Generator

This block produces fixed-frequency pulse-width modulated outputs from a duty command that is finer than its counter can resolve. A free-running counter of `CNT_W` bits sets the switching period at 2^CNT_W clock cycles. Each output is high for the first `level` counts of its period. The upper `CNT_W` bits of the command give a coarse level. The lower `DTH_W` bits choose how many periods of every group of 2^DTH_W periods get one extra count. The extra counts are spread through the group by a bit-reversed ordering, so the switching ripple stays small and its spectrum is known in advance.

A controller writes `duty_cmd` at any time. The block takes the command only at the start of a dither cycle, so every pattern is applied complete. `period_strb` marks the first cycle of each switching period, and a controller can use it to sample once per period. `dither_strb` marks the first period of a dither cycle. With `PHASES` greater than one, the block drives several outputs with the same level sequence. Each of these outputs sits at a fixed fraction of the period ahead of phase 0.

Top module: `dpwm_dither_top`

## Requirements
- R1: `period_strb` is high for exactly one clock cycle every 2^CNT_W cycles. In the default build that is every 16 cycles.
- R2: Let base be `duty_cmd[CW-1:DTH_W]` and frac be `duty_cmd[DTH_W-1:0]`. In period k (0 to 2^DTH_W-1) of a dither cycle, the applied level is base+1 when the DTH_W-bit reversal of k is less than frac. Otherwise it is base.
- R3: Across one dither cycle, phase 0 is high for a total number of cycles equal to the latched `duty_cmd` value.
- R4: The command is taken only at the boundary between dither cycles. A change of `duty_cmd` during a cycle has no effect until the next cycle. `dither_strb` is high only together with `period_strb`, in period 0.
- R5: A level of 0 holds every output low for the whole period.
- R6: A level of 2^CNT_W holds every output high for the whole period. This level is reached when base is at its maximum and the period gets the extra count.
- R7: Output i is high at cycle t exactly when phase 0 is high at cycle t + i·2^CNT_W/PHASES, taken modulo the period, while the level stays constant.
- R8: During reset, all outputs and both strobes are low. The first dither cycle after reset applies a command of zero.
- R9: Within a period, the phase-0 pulse starts in the period's first cycle (the cycle in which `period_strb` is high) and lasts for `level` cycles.
- R10: When 0 < frac ≤ 2^(DTH_W-1), no two neighbouring periods of a dither cycle both carry the extra count, counting the wrap from the last period to the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | CNT_W+DTH_W | Fine duty command: coarse level above, dither fraction below |
| pwm_out | output | PHASES | Modulated outputs, bit 0 is the reference phase |
| period_strb | output | 1 | One-cycle marker of each switching period's first cycle |
| dither_strb | output | 1 | One-cycle marker of each dither cycle's first cycle |

## Verification
The bench records whole dither cycles and checks the high time of every period. It also checks the shape of every pulse and the total high time over the cycle. A wrong bit-reversal, or a comparison that is off by one, shows up as a period count that is one too high or too low. An extra count placed in the wrong period does the same, or it breaks the spacing rule by putting two extra periods side by side. The corner cases are the fully-low level and the fully-high level, which a design with a comparator of CNT_W bits gets wrong. The bench also changes the command in mid-cycle, which a design that takes the command at once would apply to part of the cycle, and checks the first cycle after reset. The phase-shift check catches an offset with the wrong sign or the wrong size.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;

   // Reverse the low w bits of v; used to order dither periods for minimum ripple.
   function automatic logic [31:0] rev_bits(input logic [31:0] v, input int unsigned w);
      logic [31:0] r;
      r = '0;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i < w) r[i] = v[w-1-i];
      end
      return r;
   endfunction

   typedef struct packed {
      logic [15:0] coarse;
      logic [15:0] fine;
   } cmd_split_t;

endpackage

// File: rtl/dpwm_timebase.sv
`timescale 1ns/1ps
module dpwm_timebase #(
   parameter int CNT_W = 4,
   parameter int DTH_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic [DTH_W-1:0] idx,
   output logic             per_end,
   output logic             cyc_end
);

   assign per_end = (cnt == {CNT_W{1'b1}});
   assign cyc_end = per_end && (idx == {DTH_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         idx <= '0;
      end else begin
         cnt <= cnt + 1'b1;
         if (per_end) idx <= idx + 1'b1;
      end
   end

endmodule

// File: rtl/dpwm_dither.sv
`timescale 1ns/1ps
module dpwm_dither #(
   parameter int CNT_W = 4,
   parameter int DTH_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W+DTH_W-1:0] cmd,
   input  logic                   cyc_end,
   input  logic [DTH_W-1:0]       idx,
   output logic [CNT_W+DTH_W-1:0] cmd_q,
   output logic [CNT_W:0]         lvl
);
   import dpwm_pkg::*;

   localparam int CW = CNT_W + DTH_W;

   logic [CNT_W-1:0] base;
   logic [DTH_W-1:0] frac;
   logic [DTH_W-1:0] idx_rev;
   logic             bump;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cmd_q <= '0;
      else if (cyc_end) cmd_q <= cmd;
   end

   assign base    = cmd_q[CW-1:DTH_W];
   assign frac    = cmd_q[DTH_W-1:0];
   assign idx_rev = DTH_W'(rev_bits(32'(idx), DTH_W));
   assign bump    = (idx_rev < frac);
   assign lvl     = {1'b0, base} + {{CNT_W{1'b0}}, bump};

endmodule

// File: rtl/dpwm_phase.sv
`timescale 1ns/1ps
module dpwm_phase #(
   parameter int CNT_W  = 4,
   parameter int OFFSET = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W:0]   lvl,
   output logic             pwm_q
);

   localparam logic [CNT_W-1:0] OFF = CNT_W'(OFFSET);

   logic [CNT_W-1:0] pos;

   assign pos = cnt + OFF;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= ({1'b0, pos} < lvl);
   end

endmodule

// File: rtl/dpwm_dither_top.sv
`timescale 1ns/1ps
module dpwm_dither_top #(
   parameter int CNT_W  = 4,
   parameter int DTH_W  = 3,
   parameter int PHASES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W+DTH_W-1:0] duty_cmd,
   output logic [PHASES-1:0]      pwm_out,
   output logic                   period_strb,
   output logic                   dither_strb
);

   localparam int CW     = CNT_W + DTH_W;
   localparam int PERIOD = 1 << CNT_W;
   localparam int STEP   = PERIOD / PHASES;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 2..16");
   end
   if (DTH_W < 1 || DTH_W > 16) begin : g_bad_dth
      $error("DTH_W must lie in 1..16");
   end
   if (PHASES < 1 || PHASES > PERIOD || (PHASES & (PHASES - 1)) != 0) begin : g_bad_ph
      $error("PHASES must be a power of two no larger than the period");
   end

   logic [CNT_W-1:0] cnt;
   logic [DTH_W-1:0] idx;
   logic             per_end;
   logic             cyc_end;
   logic [CW-1:0]    cmd_q;
   logic [CNT_W:0]   lvl;

   dpwm_timebase #(.CNT_W(CNT_W), .DTH_W(DTH_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .idx     (idx),
      .per_end (per_end),
      .cyc_end (cyc_end)
   );

   dpwm_dither #(.CNT_W(CNT_W), .DTH_W(DTH_W)) u_dth (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (duty_cmd),
      .cyc_end (cyc_end),
      .idx     (idx),
      .cmd_q   (cmd_q),
      .lvl     (lvl)
   );

   if (PHASES == 1) begin : g_single
      dpwm_phase #(.CNT_W(CNT_W), .OFFSET(0)) u_ph (
         .clk   (clk),
         .rst_n (rst_n),
         .cnt   (cnt),
         .lvl   (lvl),
         .pwm_q (pwm_out[0])
      );
   end else begin : g_multi
      for (genvar i = 0; i < PHASES; i++) begin : g_ph
         dpwm_phase #(.CNT_W(CNT_W), .OFFSET(i * STEP)) u_ph (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt),
            .lvl   (lvl),
            .pwm_q (pwm_out[i])
         );
      end
   end

   // Strobes are registered so they line up with the registered comparator outputs.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_strb <= 1'b0;
         dither_strb <= 1'b0;
      end else begin
         period_strb <= (cnt == '0);
         dither_strb <= (cnt == '0) && (idx == '0);
      end
   end

endmodule

// File: rtl/dpwm_dither_chk.sv
`timescale 1ns/1ps
module dpwm_dither_chk #(
   parameter int CNT_W  = 4,
   parameter int DTH_W  = 3,
   parameter int PHASES = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   period_strb,
   input logic                   dither_strb,
   input logic [PHASES-1:0]      pwm_out,
   input logic [CNT_W-1:0]       cnt,
   input logic [CNT_W:0]         lvl,
   input logic [CNT_W+DTH_W-1:0] cmd_q,
   input logic                   cyc_end
);

   localparam int             PERIOD = 1 << CNT_W;
   localparam logic [CNT_W:0] FULL   = (CNT_W+1)'(PERIOD);
   localparam logic [CNT_W:0] NONE   = '0;

   int unsigned gap;
   logic        seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (period_strb) begin
         gap  <= 0;
         seen <= 1'b1;
      end else begin
         gap <= gap + 1;
      end
   end

   a_r1_period_len: assert property (@(posedge clk) disable iff (!rst_n)
      (period_strb && seen) |-> (gap == PERIOD - 1));

   a_r1_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      period_strb |=> !period_strb);

   a_r4_cycle_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      dither_strb |-> period_strb);

   a_r4_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_end |=> $stable(cmd_q));

   a_r2_level_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $stable(lvl));

   a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lvl) == NONE) |-> (pwm_out == '0));

   a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lvl) == FULL) |-> (pwm_out == {PHASES{1'b1}}));

endmodule

bind dpwm_dither_top dpwm_dither_chk #(.CNT_W(CNT_W), .DTH_W(DTH_W), .PHASES(PHASES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .period_strb (period_strb),
   .dither_strb (dither_strb),
   .pwm_out     (pwm_out),
   .cnt         (cnt),
   .lvl         (lvl),
   .cmd_q       (cmd_q),
   .cyc_end     (cyc_end)
);

// File: tb/dpwm_dither_top_tb.sv
`timescale 1ns/1ps
module dpwm_dither_top_tb;

   localparam int CNT_W  = 4;
   localparam int DTH_W  = 3;
   localparam int PHASES = 2;
   localparam int M      = 1 << CNT_W;
   localparam int D      = 1 << DTH_W;
   localparam int L      = M * D;
   localparam int CW     = CNT_W + DTH_W;
   localparam int SHIFT  = M / PHASES;
   localparam int NVEC   = 8;

   // command, expected phase-0 high cycles over one dither cycle
   localparam logic [CW-1:0] V_CMD [NVEC] = '{7'h00, 7'h01, 7'h25, 7'h44, 7'h3B, 7'h7F, 7'h50, 7'h13};
   localparam int            V_TOT [NVEC] = '{0, 1, 37, 68, 59, 127, 80, 19};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CW-1:0]     cmd = '0;
   logic [PHASES-1:0] pwm;
   logic              per_strb;
   logic              cyc_strb;

   int checks = 0;
   int fails  = 0;
   bit p0 [L];
   bit p1 [L];

   always #2.5 clk = ~clk;

   dpwm_dither_top #(.CNT_W(CNT_W), .DTH_W(DTH_W), .PHASES(PHASES)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .duty_cmd    (cmd),
      .pwm_out     (pwm),
      .period_strb (per_strb),
      .dither_strb (cyc_strb)
   );

   function automatic int brev(input int v);
      int r = 0;
      for (int i = 0; i < DTH_W; i++) r |= ((v >> i) & 1) << (DTH_W - 1 - i);
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic to_cycle_start();
      @(negedge clk);
      while (!cyc_strb) @(negedge clk);
   endtask

   task automatic capture(input bit mid, input logic [CW-1:0] mid_cmd);
      for (int t = 0; t < L; t++) begin
         p0[t] = pwm[0];
         p1[t] = pwm[1];
         if (mid && t == 37) cmd = mid_cmd;
         @(negedge clk);
      end
   endtask

   task automatic analyse(input logic [CW-1:0] c, input int exp_tot);
      int base = int'(c) >> DTH_W;
      int fr   = int'(c) & (D - 1);
      int total = 0;
      bit extra [D];
      for (int k = 0; k < D; k++) begin
         int exp = base + ((brev(k) < fr) ? 1 : 0);
         int got = 0;
         bit shape = 1'b1;
         for (int j = 0; j < M; j++) begin
            got += int'(p0[k*M+j]);
            if (p0[k*M+j] != (j < exp)) shape = 1'b0;
         end
         extra[k] = (got > base);
         if (exp == 0)      check(shape && got == 0, "R5 level zero period", got, exp);
         else if (exp == M) check(shape && got == M, "R6 level full period", got, exp);
         else               check(shape && got == exp, "R2 R9 period level and pulse shape", got, exp);
         total += got;
      end
      check(total == exp_tot, "R3 dither cycle total", total, exp_tot);
      if (fr > 0 && fr <= D / 2) begin
         int adj = 0;
         for (int k = 0; k < D; k++) if (extra[k] && extra[(k+1)%D]) adj++;
         check(adj == 0, "R10 extra periods adjacent", adj, 0);
      end
      if (fr == 0) begin
         int bad = 0;
         for (int t = 0; t + SHIFT < L; t++) if (p1[t] != p0[t+SHIFT]) bad++;
         check(bad == 0, "R7 phase offset mismatches", bad, 0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      int n;
      cmd = 7'h55;
      repeat (4) @(negedge clk);
      check(pwm == '0, "R8 outputs in reset", int'(pwm), 0);
      check(per_strb == 1'b0, "R8 period strobe in reset", int'(per_strb), 0);
      check(cyc_strb == 1'b0, "R8 dither strobe in reset", int'(cyc_strb), 0);
      rst_n = 1'b1;

      // First dither cycle after reset runs with a zero command (R8), then 0x55 (R4).
      to_cycle_start();
      capture(1'b0, '0);
      analyse(7'h00, 0);
      check(cyc_strb == 1'b1, "R4 dither strobe at cycle start", int'(cyc_strb), 1);
      capture(1'b0, '0);
      analyse(7'h55, 85);

      // Strobe spacing and width (R1)
      @(negedge clk);
      check(per_strb == 1'b0, "R1 strobe width", int'(per_strb), 0);
      n = 1;
      while (!per_strb) begin
         @(negedge clk);
         n++;
      end
      check(n == M, "R1 strobe spacing", n, M);

      // Table of commands
      for (int v = 0; v < NVEC; v++) begin
         to_cycle_start();
         cmd = V_CMD[v];
         to_cycle_start();
         capture(1'b0, '0);
         analyse(V_CMD[v], V_TOT[v]);
      end

      // Mid-cycle change ignored until the next boundary (R4)
      to_cycle_start();
      cmd = 7'h2A;
      to_cycle_start();
      capture(1'b1, 7'h71);
      analyse(7'h2A, 42);
      capture(1'b0, '0);
      analyse(7'h71, 113);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule